// File: doc/BRIEF.md
# Per-Timeslot Tristate Control Generator

This block drives one active-high tristate control line for each of sixteen TDM serial output streams. A line goes high for a whole channel time when that channel of its stream is marked high impedance. External line drivers use the line to release the wire for that timeslot. Each stream runs at its own rate of 2.048, 4.096 or 8.192 Mbps. The block follows frame and timeslot position from a 65.536 MHz clock and an active-low frame pulse.

Each control waveform can be shifted later by the same clock delay that the data stream carries. This delay covers the channel delay, the bit delay and the fractional offset of the stream. The waveform can also be moved earlier by zero to four small steps. One step is either one clock period or a quarter of a data bit. A look-ahead position sum produces the advance, so no delay line is needed. The per-channel bitmap, the rates, the delays and the advance settings are all captured at the frame boundary. Output-enable, the per-stream in-use flags and reset take effect without waiting for a frame.

Top module: `tsi_hiz_gen`

## Requirements
- R1: A frame lasts 8192 clocks. When `fp_n` is sampled low on a rising edge, the position counter restarts. The counter also wraps freely at 8192. The outputs are registered. In the cycle in which the counter holds position P, they show the value decoded for P, so the cycle right after the frame pulse shows position 0.
- R2: Rate code `rate[2s+1:2s]` selects the channel layout of stream s. Code 0 gives 32 channels of 256 clocks, code 1 gives 64 channels of 128 clocks, and codes 2 and 3 give 128 channels of 64 clocks. Output s is high for a whole channel time exactly when bit `hiz_map[s*128+ch]` is set, and low otherwise.
- R3: When `oe` is sampled low, all sixteen outputs are high from the next cycle on.
- R4: While `rst_n` is low, all sixteen outputs are high at once, without waiting for a clock edge.
- R5: When `in_use[s]` is sampled low, output s is high from the next cycle on.
- R6: Field `dly[13s+12:13s]` moves the waveform of stream s later by that many clocks, modulo the frame. Position P is then decoded as position P minus the delay.
- R7: The 3-bit field `adv_code` moves all waveforms earlier by that many steps. Codes 5 to 7 act as 4. When `adv_qbit` is 0, one step is one clock.
- R8: When `adv_qbit` is 1, one step is a quarter bit of the stream. That is 8, 4 or 2 clocks for rate codes 0, 1 and 2 or 3.
- R9: `hiz_map`, `rate`, `dly`, `adv_code` and `adv_qbit` are taken only on a frame-pulse edge. Changes made at any other time have no effect until the next frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 65.536 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_n | input | 1 | Active-low frame pulse, one clock wide |
| oe | input | 1 | Output enable; when low, all outputs are high |
| rate | input | 32 | Rate code, 2 bits per stream |
| in_use | input | 16 | Stream in-use flags |
| dly | input | 208 | Stream delay in clocks, 13 bits per stream |
| hiz_map | input | 2048 | High-impedance channel bitmap, 128 bits per stream |
| adv_code | input | 3 | Number of extra advance steps |
| adv_qbit | input | 1 | Step unit: 0 = one clock, 1 = quarter bit |
| hiz_ctl | output | 16 | Registered tristate control, one per stream |

## Verification
The hardest case to reach is the interaction of delay, advance and rate at the frame wrap. There, a shifted position crosses from the last channel of one frame into channel 0, or the reverse, and a mistake shows only in a few clocks per frame. The bench gives every stream its own rate and a different non-zero delay. It fills the bitmaps at random and forces the first and last channels on. It then runs whole frames under clock-step advances, quarter-bit advances and clamped advance codes. A scoreboard compares every clock of those frames against a position model. The frame-sampling rule is tested in its own frames. In one, every setting is changed mid-frame; in another, a frame pulse arrives early to resynchronise the counter.

// File: rtl/tsi_hiz_gen.sv
module tsi_hiz_gen #(
  parameter int NSTR       = 16,
  parameter int FRAME_CLKS = 8192,
  parameter int BASE_CH    = 32,
  parameter int DLY_W      = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fp_n,
  input  logic                       oe,
  input  logic [2*NSTR-1:0]          rate,
  input  logic [NSTR-1:0]            in_use,
  input  logic [DLY_W*NSTR-1:0]      dly,
  input  logic [NSTR*BASE_CH*4-1:0]  hiz_map,
  input  logic [2:0]                 adv_code,
  input  logic                       adv_qbit,
  output logic [NSTR-1:0]            hiz_ctl
);
  localparam int POS_W   = $clog2(FRAME_CLKS);
  localparam int MAXCH   = BASE_CH * 4;
  localparam int CH_W    = $clog2(MAXCH);
  localparam int CH_SH   = $clog2(FRAME_CLKS / BASE_CH);
  localparam int QB_CLKS = FRAME_CLKS / BASE_CH / 32;

  logic [POS_W-1:0]           pos_q, pos_nx;
  logic [NSTR*MAXCH-1:0]      map_q, map_nx;
  logic [2*NSTR-1:0]          rate_q, rate_nx;
  logic [DLY_W*NSTR-1:0]      dly_q, dly_nx;
  logic [2:0]                 code_q, code_nx, steps;
  logic                       qbit_q, qbit_nx;
  logic [NSTR-1:0]            hit;

  wire frame = !fp_n;
  assign pos_nx  = frame ? '0 : pos_q + 1'b1;
  assign map_nx  = frame ? hiz_map  : map_q;
  assign rate_nx = frame ? rate     : rate_q;
  assign dly_nx  = frame ? dly      : dly_q;
  assign code_nx = frame ? adv_code : code_q;
  assign qbit_nx = frame ? adv_qbit : qbit_q;
  assign steps   = (code_nx > 3'd4) ? 3'd4 : code_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos_q <= '0; map_q <= '0; rate_q <= '0; dly_q <= '0;
      code_q <= '0; qbit_q <= 1'b0;
    end else begin
      pos_q <= pos_nx; map_q <= map_nx; rate_q <= rate_nx; dly_q <= dly_nx;
      code_q <= code_nx; qbit_q <= qbit_nx;
    end

  for (genvar s = 0; s < NSTR; s++) begin : g_str
    logic [1:0]       rc;
    logic [5:0]       unit, adv;
    logic [POS_W-1:0] eff, sh;
    logic [3:0]       shamt;
    logic [CH_W-1:0]  ch;
    logic [MAXCH-1:0] row;

    always_comb begin
      rc    = rate_nx[2*s+1] ? 2'd2 : rate_nx[2*s +: 2];
      unit  = qbit_nx ? 6'(QB_CLKS >> rc) : 6'd1;
      adv   = 6'(steps) * unit;
      eff   = pos_nx + POS_W'(adv) - POS_W'(dly_nx[DLY_W*s +: DLY_W]);
      shamt = 4'(CH_SH) - {2'b00, rc};
      sh    = eff >> shamt;
      ch    = sh[CH_W-1:0];
      row   = map_nx[MAXCH*s +: MAXCH];
    end
    assign hit[s] = row[ch];

    p_map_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && in_use[s]) |=> ((|map_q[MAXCH*s +: MAXCH]) || !hiz_ctl[s]));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hiz_ctl <= '1;
    else        hiz_ctl <= ~({NSTR{oe}} & in_use) | hit;

  p_oe_forces_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |=> (&hiz_ctl));
  p_unused_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (~in_use != '0) |=> ((hiz_ctl | $past(in_use)) == '1));
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fp_n |=> ($stable(map_q) && $stable(dly_q) && $stable(rate_q)
              && $stable(code_q) && $stable(qbit_q)));
endmodule

// File: tb/sim_tsi_hiz_gen.sv
module sim_tsi_hiz_gen;
  localparam int N = 16;
  localparam int F = 8192;

  logic clk = 0;
  always #5 clk = ~clk;

  logic              rst_n = 0, fp_n = 1, oe = 1, adv_qbit = 0;
  logic [2*N-1:0]    rate = '0;
  logic [N-1:0]      in_use = '1;
  logic [13*N-1:0]   dly = '0;
  logic [N*128-1:0]  hiz_map = '0;
  logic [2:0]        adv_code = '0;
  logic [N-1:0]      hiz_ctl;

  tsi_hiz_gen u0 (.clk, .rst_n, .fp_n, .oe, .rate, .in_use, .dly, .hiz_map,
                  .adv_code, .adv_qbit, .hiz_ctl);

  int checks = 0, errors = 0;
  logic [N-1:0] q_exp[$];
  string        q_tag[$];

  logic [N*128-1:0] a_map;
  logic [2*N-1:0]   a_rate;
  logic [13*N-1:0]  a_dly;
  int               a_code, bpos;
  logic             a_qbit;

  function automatic logic [N-1:0] model(int p);
    logic [N-1:0] e;
    for (int s = 0; s < N; s++) begin
      int r, steps, qb, a, eff, ch;
      r = int'(a_rate[2*s +: 2]); if (r > 2) r = 2;
      steps = (a_code > 4) ? 4 : a_code;
      qb = 8 / (1 << r);
      a = steps * (a_qbit ? qb : 1);
      eff = ((p + a - int'(a_dly[13*s +: 13])) % F + F) % F;
      ch = eff / (256 / (1 << r));
      e[s] = !oe || !in_use[s] || a_map[s*128 + ch];
    end
    return e;
  endfunction

  task automatic step(string tag);
    if (!fp_n) begin
      a_map = hiz_map; a_rate = rate; a_dly = dly;
      a_code = int'(adv_code); a_qbit = adv_qbit; bpos = 0;
    end else bpos = (bpos + 1) % F;
    q_exp.push_back(model(bpos));
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic run_frame(string tag);
    fp_n = 0; step(tag);
    fp_n = 1;
    for (int i = 1; i < F; i++) step(tag);
  endtask

  task automatic fill_map();
    for (int k = 0; k < N*4; k++) hiz_map[k*32 +: 32] = $urandom;
    for (int s = 0; s < N; s++) begin
      int r; r = s % 4; if (r > 2) r = 2;
      hiz_map[s*128] = 1'b1;
      hiz_map[s*128 + (32 << r) - 1] = 1'b1;
    end
  endtask

  always begin
    @(posedge clk); #2;
    if (q_exp.size() > 0) begin
      logic [N-1:0] e; string t;
      e = q_exp.pop_front(); t = q_tag.pop_front();
      checks++;
      if (hiz_ctl !== e) begin
        errors++;
        $display("FAIL %s: hiz_ctl=%h expected=%h", t, hiz_ctl, e);
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not end (actual=hung expected=done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < N; s++) rate[2*s +: 2] = 2'(s % 4);
    fill_map();
    repeat (3) @(negedge clk);
    checks++;
    if (hiz_ctl !== '1) begin
      errors++; $display("FAIL R4: reset hiz_ctl=%h expected=ffff", hiz_ctl);
    end
    rst_n = 1;
    @(negedge clk);

    run_frame("R1 R2 base layout");
    for (int s = 0; s < N; s++) dly[13*s +: 13] = 13'(s * 211 + 3);
    fill_map();
    run_frame("R6 delay");
    adv_code = 3'd3; adv_qbit = 0;
    run_frame("R7 clock-step advance");
    adv_code = 3'd6;
    run_frame("R7 clamp code 6");
    adv_code = 3'd2; adv_qbit = 1; fill_map();
    run_frame("R8 quarter-bit advance");
    adv_code = 3'd7;
    run_frame("R8 clamp quarter-bit");

    fp_n = 0; step("R3 R5 enable and in-use");
    fp_n = 1;
    for (int i = 1; i < F; i++) begin
      oe = !(i >= 1000 && i < 1500);
      in_use[3] = (i < 4000);
      in_use[12] = (i % 700) > 100;
      step("R3 R5 enable and in-use");
    end
    oe = 1; in_use = '1;

    fp_n = 0; step("R9 mid-frame change ignored");
    fp_n = 1;
    for (int i = 1; i < 6000; i++) begin
      if (i == 2000) begin
        hiz_map = ~hiz_map; adv_code = 3'd0; adv_qbit = 0;
        rate = ~rate; dly = '0;
      end
      step("R9 mid-frame change ignored");
    end
    fp_n = 0; step("R1 early frame pulse");
    fp_n = 1;
    for (int i = 1; i < F; i++) step("R9 new settings after pulse");

    repeat (4) @(negedge clk);
    #1 rst_n = 0;
    #1;
    checks++;
    if (hiz_ctl !== '1) begin
      errors++; $display("FAIL R4: async reset hiz_ctl=%h expected=ffff", hiz_ctl);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule